// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Bank

A 32-pin general-purpose I/O controller driven through a simple memory-mapped port made of an address, a write strobe, write data and combinational read data. The pins form two banks of sixteen. Both banks use the same register layout, and the upper bank sits 0x80 bytes above the lower one. Each pin holds six feature bits: output value, output enable, input enable, two output auxiliary selects and one input auxiliary select.

Every feature register is updated atomically. In one write, the lower sixteen data bits set features and the upper sixteen bits clear them, so software never needs a read-modify-write sequence. Pad inputs pass through a two-flop synchronizer. They feed a level readback register and two latched edge status registers, one for rising edges and one for falling edges. Each edge flag is cleared by writing a one to its bit.

Top module: `atomic_gpio`

## Requirements
- R1: After reset, every feature bit and every edge flag is zero. Every register reads 0, and pad_oe_o and pad_out_o are all zero.
- R2: The byte offsets within a bank are: 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C output aux 1, 0x10 output aux 2, 0x14 input aux 1. Writing a one to data bit n (n < 16) sets that feature for bank pin n.
- R3: Writing a one to data bit n+16 clears that feature for bank pin n. If one write both sets and clears the same pin, the clear wins. Zero bits leave their features unchanged.
- R4: Address bit 7 selects the bank. Offsets 0x80 and above control pins 16–31, with pin 16+n at data bit n.
- R5: Reading any register returns its sixteen bank bits in rdata_o[15:0] and zero in rdata_o[31:16]. Unmapped offsets read zero.
- R6: pad_oe_o follows the output enable bits. pad_out_o carries the output value where output enable is set and is 0 elsewhere, where the pad is released.
- R7: The readback register at offset 0x18 reports the synchronized pad level two clock edges after the pad changes. It reads zero for pins whose input enable is clear.
- R8: The rising-edge register at offset 0x1C and the falling-edge register at offset 0x20 latch a synchronized transition, but only while that pin's input enable is set.
- R9: Writing a one to the low half of an edge register clears that flag. The upper data half and zero bits have no effect on the flags. A new edge in the same cycle as a clear keeps the flag set.
- R10: Pins 23, 29, 30 and 31 are reserved. They have no storage, never drive their pads and always read zero.
- R11: out_aux1_o, out_aux2_o and in_aux1_o present the aux select bits of all 32 pins. A write to one feature register leaves all other feature registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address; bit 7 selects the bank |
| wdata_i | input | 32 | Write data: set half [15:0], clear half [31:16] |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pad_in_i | input | 32 | Pad input levels (asynchronous) |
| pad_out_o | output | 32 | Pad output value |
| pad_oe_o | output | 32 | Pad output enable |
| out_aux1_o | output | 32 | Output aux 1 select per pin |
| out_aux2_o | output | 32 | Output aux 2 select per pin |
| in_aux1_o | output | 32 | Input aux 1 select per pin |

## Verification
A wrong feature bit shows up one cycle after the write that caused it. It appears on the pad or aux outputs and in the combinational read of that register. A bank or half decode error shows as a pin in the wrong bank or as a set and clear swapped. A fault in the synchronizer or the edge logic shows in the readback value two edges after a pad change, or in an edge flag one edge later. The bench samples at exactly those edges, so a latency that is off by one also fails.

// File: rtl/atomic_gpio_pkg.sv
package atomic_gpio_pkg;
  localparam int NPIN  = 32;
  localparam int BANKW = 16;
  localparam int NFEAT = 6;
  localparam logic [NPIN-1:0] RSVD_PINS = 32'hE080_0000;

  typedef enum logic [4:0] {
    IX_OVAL  = 5'd0,
    IX_OEN   = 5'd1,
    IX_IEN   = 5'd2,
    IX_OAUX1 = 5'd3,
    IX_OAUX2 = 5'd4,
    IX_IAUX1 = 5'd5,
    IX_LEVEL = 5'd6,
    IX_RISE  = 5'd7,
    IX_FALL  = 5'd8
  } reg_ix_e;
endpackage

// File: rtl/agpio_sync.sv
module agpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/agpio_pin.sv
module agpio_pin
  import atomic_gpio_pkg::*;
#(
  parameter bit RSVD = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFEAT-1:0] set_i,
  input  logic [NFEAT-1:0] clr_i,
  input  logic             rise_clr_i,
  input  logic             fall_clr_i,
  input  logic             lvl_i,
  output logic [NFEAT-1:0] feat_o,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  if (RSVD) begin : g_rsvd
    assign feat_o  = '0;
    assign level_o = 1'b0;
    assign rise_o  = 1'b0;
    assign fall_o  = 1'b0;
  end else begin : g_pin
    logic [NFEAT-1:0] feat_q;
    logic             prev_q, rise_q, fall_q, ien;
    assign ien = feat_q[IX_IEN];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        feat_q <= '0;
        prev_q <= 1'b0;
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        // clear wins over set
        feat_q <= (feat_q | set_i) & ~clr_i;
        prev_q <= lvl_i;
        // a new edge wins over a clear
        rise_q <= (rise_q & ~rise_clr_i) | (ien & lvl_i & ~prev_q);
        fall_q <= (fall_q & ~fall_clr_i) | (ien & ~lvl_i & prev_q);
      end
    end
    assign feat_o  = feat_q;
    assign level_o = lvl_i & ien;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;
  end
endmodule

// File: rtl/atomic_gpio.sv
module atomic_gpio
  import atomic_gpio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] pad_in_i,
  output logic [31:0] pad_out_o,
  output logic [31:0] pad_oe_o,
  output logic [31:0] out_aux1_o,
  output logic [31:0] out_aux2_o,
  output logic [31:0] in_aux1_o
);
  localparam int NBANK = NPIN / BANKW;

  logic [4:0]           ix;
  logic [4:0]           base;
  logic [NPIN-1:0]      lvl_s;
  logic [NFEAT-1:0][NPIN-1:0] set_v, clr_v, feat_t;
  logic [NPIN-1:0]      rclr_v, fclr_v, level_v, rise_v, fall_v;
  logic [NFEAT-1:0]     pin_set  [NPIN];
  logic [NFEAT-1:0]     pin_clr  [NPIN];
  logic [NFEAT-1:0]     pin_feat [NPIN];

  assign ix   = addr_i[6:2];
  assign base = {addr_i[7], 4'b0000};

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    rclr_v = '0;
    fclr_v = '0;
    if (we_i) begin
      if (ix < 5'(NFEAT)) begin
        set_v[ix[2:0]][base +: BANKW] = wdata_i[BANKW-1:0];
        clr_v[ix[2:0]][base +: BANKW] = wdata_i[31:BANKW];
      end else if (ix == IX_RISE) begin
        rclr_v[base +: BANKW] = wdata_i[BANKW-1:0];
      end else if (ix == IX_FALL) begin
        fclr_v[base +: BANKW] = wdata_i[BANKW-1:0];
      end
    end
  end

  agpio_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl_s)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pins
    for (genvar f = 0; f < NFEAT; f++) begin : g_map
      assign pin_set[p][f] = set_v[f][p];
      assign pin_clr[p][f] = clr_v[f][p];
      assign feat_t[f][p]  = pin_feat[p][f];
    end
    agpio_pin #(.RSVD(RSVD_PINS[p])) u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (pin_set[p]),
      .clr_i     (pin_clr[p]),
      .rise_clr_i(rclr_v[p]),
      .fall_clr_i(fclr_v[p]),
      .lvl_i     (lvl_s[p]),
      .feat_o    (pin_feat[p]),
      .level_o   (level_v[p]),
      .rise_o    (rise_v[p]),
      .fall_o    (fall_v[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (ix < 5'(NFEAT))      rdata_o[BANKW-1:0] = feat_t[ix[2:0]][base +: BANKW];
    else if (ix == IX_LEVEL) rdata_o[BANKW-1:0] = level_v[base +: BANKW];
    else if (ix == IX_RISE)  rdata_o[BANKW-1:0] = rise_v[base +: BANKW];
    else if (ix == IX_FALL)  rdata_o[BANKW-1:0] = fall_v[base +: BANKW];
  end

  assign pad_oe_o   = feat_t[IX_OEN];
  assign pad_out_o  = feat_t[IX_OVAL] & feat_t[IX_OEN];
  assign out_aux1_o = feat_t[IX_OAUX1];
  assign out_aux2_o = feat_t[IX_OAUX2];
  assign in_aux1_o  = feat_t[IX_IAUX1];

  if (NBANK != 2) begin : g_bad_cfg
    initial $error("atomic_gpio expects two banks");
  end
endmodule

// File: rtl/atomic_gpio_chk.sv
module atomic_gpio_chk
  import atomic_gpio_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [31:0] pad_out_o,
  input logic [31:0] pad_oe_o,
  input logic [31:0] out_aux1_o
);
  assert_set_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h0C) |=>
      ((out_aux1_o[15:0] & ($past(wdata_i[15:0]) & ~$past(wdata_i[31:16])))
        == ($past(wdata_i[15:0]) & ~$past(wdata_i[31:16]))));

  assert_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h04) |=> ((pad_oe_o[15:0] & $past(wdata_i[31:16])) == 16'h0));

  assert_high_bank_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h84) |=> ((pad_oe_o[31:16] & $past(wdata_i[31:16])) == 16'h0));

  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:16] == 16'h0);

  assert_pad_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == 32'h0);

  assert_rsvd_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & RSVD_PINS) == 32'h0);

  assert_other_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h00) |=> $stable(out_aux1_o));
endmodule

bind atomic_gpio atomic_gpio_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .out_aux1_o(out_aux1_o)
);

// File: tb/atomic_gpio_tb.sv
module atomic_gpio_tb;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe, aux1, aux2, iaux1;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  atomic_gpio u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .out_aux1_o(aux1), .out_aux2_o(aux2), .in_aux1_o(iaux1)
  );

  // {addr, wdata, expected read of same addr after the write}
  localparam logic [71:0] VEC [8] = '{
    {8'h0C, 32'h0000_00FF, 32'h0000_00FF},  // R2 set
    {8'h0C, 32'h000F_0000, 32'h0000_00F0},  // R3 clear
    {8'h0C, 32'h0010_0010, 32'h0000_00E0},  // R3 clear wins
    {8'h8C, 32'h0000_FFFF, 32'h0000_1F7F},  // R4 R10 high bank, reserved
    {8'h8C, 32'hFFFF_0000, 32'h0000_0000},  // R4 high bank clear
    {8'h10, 32'hABCD_1234, 32'h0000_1030},  // R3 mixed
    {8'h14, 32'h0000_8001, 32'h0000_8001},  // R2 input aux
    {8'h0C, 32'h0000_0000, 32'h0000_00E0}   // R3 zeros keep state
  };

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    edges(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(8'(a * 4), r);        check("R1", r, 32'h0);
      rd(8'(a * 4 + 128), r);  check("R1", r, 32'h0);
    end
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      check($sformatf("R2/R3/R4 vec%0d", i), r, VEC[i][31:0]);
    end
    check("R11 aux1", aux1, 32'h0000_00E0);
    check("R11 aux2", aux2, 32'h0000_1030);
    check("R11 iaux1", iaux1, 32'h0000_8001);
    rd(8'h24, r);  check("R5 unmapped", r, 32'h0);

    // R6 pad drive
    wr(8'h00, 32'h0000_0003);
    wr(8'h04, 32'h0000_0001);
    check("R6 oe", pad_oe, 32'h0000_0001);
    check("R6 out", pad_out, 32'h0000_0001);
    wr(8'h84, 32'h0000_0001);
    wr(8'h80, 32'h0000_0001);
    check("R4 oe", pad_oe, 32'h0001_0001);
    check("R4 out", pad_out, 32'h0001_0001);
    wr(8'h84, 32'h0000_FFFF);
    check("R10 oe", pad_oe & 32'hE080_0000, 32'h0);
    check("R10 oe high", pad_oe[31:16], 16'h1F7F);

    // R7 readback gated by input enable
    @(negedge clk); pad_in[2] = 1'b1;
    edges(4);
    rd(8'h18, r);  check("R7 gated", r, 32'h0);
    rd(8'h1C, r);  check("R8 no edge when disabled", r, 32'h0);
    wr(8'h08, 32'h0000_000C);
    rd(8'h18, r);  check("R7 enabled", r, 32'h4);
    pad_in[3] = 1'b1;
    edges(1);
    rd(8'h18, r);  check("R7 one edge", r, 32'h4);
    edges(1);
    rd(8'h18, r);  check("R7 two edges", r, 32'hC);
    rd(8'h1C, r);  check("R8 rise not yet", r, 32'h0);
    edges(1);
    rd(8'h1C, r);  check("R8 rise", r, 32'h8);
    wr(8'h1C, 32'h0008_0000);
    rd(8'h1C, r);  check("R9 upper ignored", r, 32'h8);
    wr(8'h1C, 32'h0000_0008);
    rd(8'h1C, r);  check("R9 cleared", r, 32'h0);
    pad_in[3] = 1'b0;
    edges(3);
    rd(8'h20, r);  check("R8 fall", r, 32'h8);
    rd(8'h1C, r);  check("R8 no rise on fall", r, 32'h0);
    wr(8'h20, 32'h0000_0000);
    rd(8'h20, r);  check("R9 zeros keep", r, 32'h8);
    wr(8'h20, 32'h0000_0008);
    rd(8'h20, r);  check("R9 fall cleared", r, 32'h0);

    // R7/R8 high bank, reserved pin 23 stays quiet
    wr(8'h88, 32'h0000_0081);
    pad_in[16] = 1'b1; pad_in[23] = 1'b1;
    edges(3);
    rd(8'h98, r);  check("R7 high", r, 32'h1);
    rd(8'h9C, r);  check("R10 rise high", r, 32'h1);
    finish_run();
  end
endmodule